// File: doc/BRIEF.md
# Indirect Extended RAM Access Port

This block lets a byte-wide host reach a 4096-byte memory through a narrow register window instead of a wide address bus. The host loads a 12-bit pointer through two pointer registers (a low byte and a right-justified high nibble) and then moves data through a single data register, which reads or writes the byte at the pointer. An auto-advance mode makes the pointer step forward after each data-register access, so consecutive bytes stream through the window without reloading the pointer.

The extended registers live in a second register bank. A bank-select bit in a control register, visible in both banks, switches them in. The burst-enable bit lives in an extended control register inside that bank. The host uses active-low read and write strobes sampled on the block clock. A write takes effect when its strobe returns high. Read data is driven while the read strobe is low. The memory itself sits outside the block, which drives its address, write data, write strobe and read strobe and takes its asynchronous read data.

Top module: `xram_indirect_port`

## Requirements
- R1: After reset the pointer is 0x000, the bank-select bit is 0 and the burst-enable bit is 0, and `host_rdata` is 0 while no read strobe is low.
- R2: Register 0x0A is reachable in both banks. Bit 4 is the bank-select bit: 1 selects the extended bank. Its other bits read as 0 and ignore writes.
- R3: With the extended bank selected, writing register 0x50 loads pointer bits 7:0, and reading it returns them.
- R4: With the extended bank selected, writing register 0x51 loads pointer bits 11:8 from data bits 3:0. Reading 0x51 returns those bits in bits 3:0 and 0 in bits 7:4.
- R5: A write to register 0x53 in the extended bank gives exactly one `mem_we` cycle. That cycle is the first cycle after `host_wr_n` returns high, with `mem_addr` equal to the pointer and `mem_wdata` equal to the written byte.
- R6: While `host_rd_n` is low on register 0x53 in the extended bank, `mem_re` is 1, `mem_addr` is the pointer and `host_rdata` is the memory byte at the pointer.
- R7: With burst-enable 0, reads and writes of register 0x53 leave the pointer unchanged.
- R8: With burst-enable 1, the pointer increments by one when the strobe of each 0x53 access returns high. Accesses to other registers do not advance it.
- R9: In burst mode the pointer wraps from 0xFFF to 0x000.
- R10: With the bank-select bit 0, accesses to 0x4A to 0x53 raise neither `mem_we` nor `mem_re`, leave the pointer and burst-enable bit unchanged, and read as 0.
- R11: Register 0x4A in the extended bank holds the burst-enable bit in bit 0. Its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rd_n | input | 1 | Active-low host read strobe |
| host_wr_n | input | 1 | Active-low host write strobe |
| host_rdata | output | 8 | Host read data, valid while `host_rd_n` is low |
| mem_addr | output | 12 | Memory address (the pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle per write |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory asynchronous read data |

## Verification
Assertions check several rules on every cycle. The pointer holds when it is neither loaded nor stepped, and a step adds exactly one with wrap. No memory strobe fires while the base bank is selected. The burst bit changes only from the extended bank. The high-pointer read keeps its upper nibble at zero. Only bench scenarios can show that the right byte lands at the right address, that a burst stream reads back in order, and that base-bank traffic leaves the stored data and pointer intact when the extended bank is selected again.

// File: rtl/xram_port_pkg.sv
package xram_port_pkg;

    // register offsets on the host side
    localparam logic [7:0] OFS_CTLA = 8'h0A;
    localparam logic [7:0] OFS_XCTL = 8'h4A;
    localparam logic [7:0] OFS_PLO  = 8'h50;
    localparam logic [7:0] OFS_PHI  = 8'h51;
    localparam logic [7:0] OFS_DAT  = 8'h53;

    // one flag per decoded register
    typedef struct packed {
        logic ctla;
        logic xctl;
        logic plo;
        logic phi;
        logic dat;
    } reg_hit_t;

endpackage

// File: rtl/xram_strobe_track.sv
module xram_strobe_track #(
    parameter int DW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [RW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_done,
    output logic          wr_done,
    output logic [RW-1:0] cap_addr,
    output logic [DW-1:0] cap_data
);

    typedef struct packed {
        logic          rd_low;
        logic          wr_low;
        logic [RW-1:0] addr;
        logic [DW-1:0] data;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d        = trk_q;
        trk_d.rd_low = !rd_n;
        trk_d.wr_low = !wr_n;
        if (!rd_n || !wr_n) begin
            trk_d.addr = addr;
            trk_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // an access ends on the cycle its strobe is seen high again
    assign rd_done  = trk_q.rd_low & rd_n;
    assign wr_done  = trk_q.wr_low & wr_n;
    assign cap_addr = trk_q.addr;
    assign cap_data = trk_q.data;

endmodule

// File: rtl/xram_reg_decode.sv
module xram_reg_decode
    import xram_port_pkg::*;
(
    input  logic [7:0] addr,
    input  logic       bank1,
    output reg_hit_t   hit
);

    always_comb begin
        hit      = '0;
        hit.ctla = (addr == OFS_CTLA);
        hit.xctl = bank1 && (addr == OFS_XCTL);
        hit.plo  = bank1 && (addr == OFS_PLO);
        hit.phi  = bank1 && (addr == OFS_PHI);
        hit.dat  = bank1 && (addr == OFS_DAT);
    end

endmodule

// File: rtl/xram_ctrl_regs.sv
module xram_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic hit_ctla,
    input  logic hit_xctl,
    input  logic bank_in,
    input  logic burst_in,
    output logic bank_q,
    output logic burst_q
);

    typedef struct packed {
        logic bank;
        logic burst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (commit && hit_ctla) ctl_d.bank  = bank_in;
        if (commit && hit_xctl) ctl_d.burst = burst_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign bank_q  = ctl_q.bank;
    assign burst_q = ctl_q.burst;

    // R10: the burst bit only moves while the extended bank was selected
    a_r10_burst_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.burst) |-> $past(ctl_q.bank));

endmodule

// File: rtl/xram_pointer.sv
module xram_pointer #(
    parameter int AW = 12,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             step,
    input  logic [LW-1:0]    lo_data,
    input  logic [AW-LW-1:0] hi_data,
    output logic [AW-1:0]    ptr
);

    localparam int HW = AW - LW;
    localparam logic [AW-1:0] PTR_MAX = '1;

    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ld_lo || ld_hi) begin
            if (ld_lo) ptr_d.ptr[LW-1:0]  = lo_data;
            if (ld_hi) ptr_d.ptr[AW-1:LW] = hi_data[HW-1:0];
        end else if (step) begin
            ptr_d.ptr = ptr_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q.ptr;

    // R7: without a load or a step the pointer holds
    a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_lo && !ld_hi && !step) |=> $stable(ptr_q.ptr));

    // R8: a step moves the pointer forward by exactly one
    a_r8_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi) |=> (ptr_q.ptr == ($past(ptr_q.ptr) + 1'b1)));

    // R9: stepping from the top address lands on zero
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi && ptr_q.ptr == PTR_MAX) |=> (ptr_q.ptr == '0));

endmodule

// File: rtl/xram_indirect_port.sv
module xram_indirect_port
    import xram_port_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 12,
    parameter int BANK_BIT  = 4,
    parameter int BURST_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata
);

    localparam int HI_W = AW - DW;

    logic          rd_done, wr_done;
    logic [7:0]    cap_addr;
    logic [DW-1:0] cap_data;
    logic          bank_q, burst_q;
    logic [AW-1:0] ptr;
    reg_hit_t      live_hit, cap_hit;
    logic          ld_lo, ld_hi, step;

    xram_strobe_track #(.DW(DW), .RW(8)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_n     (host_rd_n),
        .wr_n     (host_wr_n),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .rd_done  (rd_done),
        .wr_done  (wr_done),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    // live decode serves reads, captured decode serves completions
    xram_reg_decode u_dec_live (
        .addr  (host_addr),
        .bank1 (bank_q),
        .hit   (live_hit)
    );

    xram_reg_decode u_dec_cap (
        .addr  (cap_addr),
        .bank1 (bank_q),
        .hit   (cap_hit)
    );

    xram_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (wr_done),
        .hit_ctla (cap_hit.ctla),
        .hit_xctl (cap_hit.xctl),
        .bank_in  (cap_data[BANK_BIT]),
        .burst_in (cap_data[BURST_BIT]),
        .bank_q   (bank_q),
        .burst_q  (burst_q)
    );

    always_comb begin
        ld_lo = wr_done && cap_hit.plo;
        ld_hi = wr_done && cap_hit.phi;
        step  = (wr_done || rd_done) && cap_hit.dat && burst_q;
    end

    xram_pointer #(.AW(AW), .LW(DW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .step    (step),
        .lo_data (cap_data),
        .hi_data (cap_data[HI_W-1:0]),
        .ptr     (ptr)
    );

    always_comb begin
        mem_addr  = ptr;
        mem_wdata = cap_data;
        mem_we    = wr_done && cap_hit.dat;
        mem_re    = !host_rd_n && live_hit.dat;
    end

    always_comb begin
        host_rdata = '0;
        if (!host_rd_n) begin
            if (live_hit.ctla)      host_rdata[BANK_BIT]  = bank_q;
            else if (live_hit.xctl) host_rdata[BURST_BIT] = burst_q;
            else if (live_hit.plo)  host_rdata            = ptr[DW-1:0];
            else if (live_hit.phi)  host_rdata[HI_W-1:0]  = ptr[AW-1:DW];
            else if (live_hit.dat)  host_rdata            = mem_rdata;
        end
    end

    // R10: base bank never strobes the memory
    a_r10_bank0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_q |-> (!mem_we && !mem_re));

    // R4: high pointer read keeps its upper nibble clear
    a_r4_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd_n && host_addr == OFS_PHI) |-> (host_rdata[DW-1:HI_W] == '0));

    // R5: a memory write follows a write strobe that was low the cycle before
    a_r5_we_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (host_wr_n && $past(!host_wr_n)));

    // R6: the memory is read only under a low read strobe
    a_r6_re_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> !host_rd_n);

endmodule

// File: tb/xram_indirect_port_tb_top.sv
module xram_indirect_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic       is_wr;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] req;
    } vec_t;

    // reads compare against d, writes store d
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h0A, 8'h00, 8'd1},   // R1
        '{1'b1, 8'h0A, 8'hFF, 8'd2},   // R2
        '{1'b0, 8'h0A, 8'h10, 8'd2},
        '{1'b0, 8'h50, 8'h00, 8'd1},
        '{1'b0, 8'h51, 8'h00, 8'd1},
        '{1'b0, 8'h4A, 8'h00, 8'd1},
        '{1'b1, 8'h50, 8'h3C, 8'd3},   // R3
        '{1'b0, 8'h50, 8'h3C, 8'd3},
        '{1'b1, 8'h51, 8'hA7, 8'd4},   // R4
        '{1'b0, 8'h51, 8'h07, 8'd4},
        '{1'b0, 8'h50, 8'h3C, 8'd3},
        '{1'b1, 8'h53, 8'h5A, 8'd5},   // R5
        '{1'b0, 8'h53, 8'h5A, 8'd6},   // R6
        '{1'b0, 8'h53, 8'h5A, 8'd7},   // R7
        '{1'b0, 8'h50, 8'h3C, 8'd7},
        '{1'b0, 8'h51, 8'h07, 8'd7},
        '{1'b1, 8'h4A, 8'hFF, 8'd11},  // R11
        '{1'b0, 8'h4A, 8'h01, 8'd11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [7:0]  host_rdata;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem [0:4095];

    int n_cmp = 0;
    int n_bad = 0;
    int we_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    xram_indirect_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rd_n  (host_rd_n),
        .host_wr_n  (host_wr_n),
        .host_rdata (host_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_rdata  (mem_rdata)
    );

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd_n = 1'b0;
        @(negedge clk);
        d = host_rdata;
        host_rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        wrap_up();
    end

    initial begin
        int base;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check("R1", host_rdata, 0);
        check("R1", {mem_we, mem_re}, 0);
        check("R1", mem_addr, 0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                bus_wr(VECS[i].a, VECS[i].d);
            end else begin
                bus_rd(VECS[i].a, v);
                check($sformatf("R%0d", VECS[i].req), v, VECS[i].d);
            end
        end

        // R8: burst writes then burst reads stream in order
        bus_wr(8'h50, 8'h10); bus_wr(8'h51, 8'h00);
        rd_chk("R8", 8'h50, 8'h10);
        bus_wr(8'h53, 8'h11); bus_wr(8'h53, 8'h22); bus_wr(8'h53, 8'h33);
        rd_chk("R8", 8'h50, 8'h13);
        bus_wr(8'h50, 8'h10);
        rd_chk("R8", 8'h53, 8'h11);
        rd_chk("R8", 8'h53, 8'h22);
        rd_chk("R8", 8'h53, 8'h33);
        rd_chk("R8", 8'h4A, 8'h01);
        rd_chk("R8", 8'h50, 8'h13);

        // R9: wrap from the top address
        bus_wr(8'h50, 8'hFF); bus_wr(8'h51, 8'h0F);
        bus_wr(8'h53, 8'hEE);
        rd_chk("R9", 8'h50, 8'h00);
        rd_chk("R9", 8'h51, 8'h00);
        bus_wr(8'h50, 8'hFF); bus_wr(8'h51, 8'h0F);
        rd_chk("R9", 8'h53, 8'hEE);
        rd_chk("R9", 8'h50, 8'h00);

        // R5: one memory write per data write
        base = we_cnt;
        bus_wr(8'h53, 8'h42);
        check("R5", we_cnt - base, 1);
        bus_wr(8'h53, 8'h5F);
        check("R5", we_cnt - base, 2);
        bus_wr(8'h50, 8'h01);

        // R10: base bank leaves extended state alone
        bus_wr(8'h0A, 8'h00);
        rd_chk("R2", 8'h0A, 8'h00);
        base = we_cnt;
        bus_wr(8'h50, 8'h99);
        bus_wr(8'h4A, 8'h00);
        bus_wr(8'h53, 8'h77);
        rd_chk("R10", 8'h53, 8'h00);
        rd_chk("R10", 8'h50, 8'h00);
        check("R10", we_cnt - base, 0);
        bus_wr(8'h0A, 8'h10);
        rd_chk("R10", 8'h4A, 8'h01);
        rd_chk("R10", 8'h50, 8'h01);
        rd_chk("R10", 8'h53, 8'h5F);
        rd_chk("R8", 8'h50, 8'h02);

        // R7: burst off again, data reads do not move the pointer
        bus_wr(8'h4A, 8'h00);
        bus_wr(8'h50, 8'h00);
        rd_chk("R7", 8'h53, 8'h42);
        rd_chk("R7", 8'h53, 8'h42);
        rd_chk("R7", 8'h50, 8'h00);

        wrap_up();
    end

endmodule